// File: doc/BRIEF.md
# Tri-State PWM Command Qualifier

This block sits between a pair of threshold comparators that watch a three-level PWM command pin and the gate-drive logic of a half-bridge. Each comparator reports one bit: one is set while the pin is above the upper threshold, the other while it is below the lower threshold. The block resynchronises both bits, decodes them into a high, low or middle level, and turns that level into registered requests for the upper switch, for the lower switch, and a shutdown flag.

A high level asks for the upper switch and a low level asks for the lower switch, so the path does not invert. A middle level, which a floating pin also produces, must last for a programmable dwell before shutdown is declared. During that dwell the last valid command is kept. Once the pin returns to a valid level, shutdown clears at once and the new command takes effect with the normal pipeline latency.

Top module: `pwm_tristate_qualifier`

## Requirements
- R1: While the synchronous reset is high, all three outputs are 0 from the next clock edge on. After reset the synchroniser holds code 00, which decodes as the middle level.
- R2: Code above=1, below=0 (high level) gives hs_req=1, ls_req=0 and shutdown=0 at the third rising edge after it is applied.
- R3: Code above=0, below=1 (low level) gives ls_req=1, hs_req=0 and shutdown=0 at the third rising edge after it is applied.
- R4: Code 00 (middle level) held for HOLD_CYCLES+1 or more consecutive clock cycles sets shutdown=1 with hs_req=ls_req=0. The rise happens at the (HOLD_CYCLES+3)-th rising edge after the code is applied.
- R5: A middle-level run of HOLD_CYCLES cycles or fewer does not set shutdown. During the run all outputs keep the values they had before it.
- R6: Shutdown clears without any dwell. The first valid code after a middle run shows up at the outputs with the same latency as in R2 and R3.
- R7: Code 11, where both comparators are set, is illegal. It is treated as the middle level, including for the dwell count.
- R8: The dwell count restarts whenever a valid code is decoded, so middle runs split by a valid cycle do not add up.
- R9: hs_req and ls_req are never both 1, and shutdown=1 forces both to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_above | input | 1 | Asynchronous comparator bit: pin above the upper threshold |
| cmp_below | input | 1 | Asynchronous comparator bit: pin below the lower threshold |
| hs_req | output | 1 | Upper-switch drive request |
| ls_req | output | 1 | Lower-switch drive request |
| shutdown | output | 1 | Qualified tri-state shutdown flag |

## Verification
The assertions assume that the decoded level is stable within one clock and that a comparator bit changes at most once per cycle. They check cause and effect one edge after the synchroniser output, so metastability inside the first flop is not modelled. The stimulus changes both comparator bits together on the falling clock edge. It draws run lengths at random, with extra weight near HOLD_CYCLES and HOLD_CYCLES+1, and mixes the illegal 11 code in with 00 so that every middle-level path is exercised.

// File: rtl/pwmq_pkg.sv
package pwmq_pkg;

    typedef enum logic [1:0] {
        LVL_MID  = 2'd0,
        LVL_HIGH = 2'd1,
        LVL_LOW  = 2'd2
    } level_t;

    typedef struct packed {
        logic hs;
        logic ls;
        logic sd;
    } drive_req_t;

    localparam drive_req_t REQ_IDLE = '{hs: 1'b0, ls: 1'b0, sd: 1'b0};
    localparam drive_req_t REQ_HIGH = '{hs: 1'b1, ls: 1'b0, sd: 1'b0};
    localparam drive_req_t REQ_LOW  = '{hs: 1'b0, ls: 1'b1, sd: 1'b0};
    localparam drive_req_t REQ_OFF  = '{hs: 1'b0, ls: 1'b0, sd: 1'b1};

    // above/below comparator pair to level; 00 and 11 both mean the window
    function automatic level_t decode_level(input logic above, input logic below);
        level_t l;
        unique case ({above, below})
            2'b10:   l = LVL_HIGH;
            2'b01:   l = LVL_LOW;
            default: l = LVL_MID;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/pwmq_sync.sv
module pwmq_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage[s] <= '0;
                    else     stage[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage[s] <= '0;
                    else     stage[s] <= stage[s-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/pwmq_holdoff.sv
module pwmq_holdoff
    import pwmq_pkg::*;
#(
    parameter int HOLD_CYCLES = 24
) (
    input  logic   clk,
    input  logic   rst,
    input  level_t lvl,
    output logic   expired
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYCLES);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (lvl != LVL_MID) begin
            cnt <= '0;
        end else if (cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (lvl == LVL_MID) && (cnt == LIMIT);
endmodule

// File: rtl/pwmq_outreg.sv
module pwmq_outreg
    import pwmq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  level_t     lvl,
    input  logic       expired,
    output drive_req_t req
);
    drive_req_t nxt;

    always_comb begin
        nxt = req;
        unique case (lvl)
            LVL_HIGH: nxt = REQ_HIGH;
            LVL_LOW:  nxt = REQ_LOW;
            default:  if (expired) nxt = REQ_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) req <= REQ_IDLE;
        else     req <= nxt;
    end
endmodule

// File: rtl/pwm_tristate_qualifier.sv
module pwm_tristate_qualifier
    import pwmq_pkg::*;
#(
    parameter int HOLD_CYCLES = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cmp_above,
    input  logic cmp_below,
    output logic hs_req,
    output logic ls_req,
    output logic shutdown
);
    logic [1:0] cmp_sync;
    level_t     lvl;
    logic       hold_done;
    drive_req_t req;

    pwmq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cmp_above, cmp_below}),
        .q   (cmp_sync)
    );

    assign lvl = decode_level(cmp_sync[1], cmp_sync[0]);

    pwmq_holdoff #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .lvl     (lvl),
        .expired (hold_done)
    );

    pwmq_outreg u_out (
        .clk     (clk),
        .rst     (rst),
        .lvl     (lvl),
        .expired (hold_done),
        .req     (req)
    );

    assign hs_req   = req.hs;
    assign ls_req   = req.ls;
    assign shutdown = req.sd;
endmodule

// File: rtl/pwmq_checker.sv
module pwmq_checker
    import pwmq_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input level_t lvl,
    input logic   hold_done,
    input logic   hs_req,
    input logic   ls_req,
    input logic   shutdown
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!hs_req && !ls_req && !shutdown));

    assert_high_follows_R2: assert property (@(posedge clk) disable iff (rst)
        (lvl == LVL_HIGH) |=> (hs_req && !ls_req && !shutdown));

    assert_low_follows_R3: assert property (@(posedge clk) disable iff (rst)
        (lvl == LVL_LOW) |=> (ls_req && !hs_req && !shutdown));

    assert_shutdown_after_dwell_R4: assert property (@(posedge clk) disable iff (rst)
        hold_done |=> (shutdown && !hs_req && !ls_req));

    assert_hold_during_dwell_R5: assert property (@(posedge clk) disable iff (rst)
        ((lvl == LVL_MID) && !hold_done) |=>
            ($stable(hs_req) && $stable(ls_req) && $stable(shutdown)));

    assert_rise_only_from_window_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(shutdown) |-> $past(lvl == LVL_MID));

    assert_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        $countones({hs_req, ls_req, shutdown}) <= 1);
endmodule

bind pwm_tristate_qualifier pwmq_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .lvl       (lvl),
    .hold_done (hold_done),
    .hs_req    (hs_req),
    .ls_req    (ls_req),
    .shutdown  (shutdown)
);

// File: tb/tb_pwm_tristate_qualifier.sv
`timescale 1ns/1ps
module tb_pwm_tristate_qualifier;
    localparam int HOLD = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic above = 1'b0;
    logic below = 1'b0;
    logic hs_req, ls_req, shutdown;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    string phase = "R1";

    pwm_tristate_qualifier #(.HOLD_CYCLES(HOLD)) dut (
        .clk      (clk),
        .rst      (rst),
        .cmp_above(above),
        .cmp_below(below),
        .hs_req   (hs_req),
        .ls_req   (ls_req),
        .shutdown (shutdown)
    );

    always #5 clk = ~clk;

    // reference built from requirements: 2 sync edges, then register
    logic [1:0] m_p1 = 2'b00, m_p2 = 2'b00;
    int m_run = 0;
    logic m_hs = 1'b0, m_ls = 1'b0, m_sd = 1'b0;

    function automatic bit is_mid(input logic [1:0] c);
        return (c == 2'b00) || (c == 2'b11);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_p1 = 2'b00; m_p2 = 2'b00; m_run = 0;
            m_hs = 1'b0; m_ls = 1'b0; m_sd = 1'b0;
        end else begin
            if (m_p2 == 2'b10) begin
                m_hs = 1'b1; m_ls = 1'b0; m_sd = 1'b0;
            end else if (m_p2 == 2'b01) begin
                m_hs = 1'b0; m_ls = 1'b1; m_sd = 1'b0;
            end else if (m_run + 1 > HOLD) begin
                m_hs = 1'b0; m_ls = 1'b0; m_sd = 1'b1;
            end
            m_run = is_mid(m_p2) ? m_run + 1 : 0;
            m_p2 = m_p1;
            m_p1 = {above, below};
        end
    end

    task automatic check_now();
        string tag;
        if (rst) tag = "R1";
        else if (m_sd) tag = "R4";
        else if (is_mid(m_p2)) tag = "R5";
        else if (m_hs) tag = "R2";
        else tag = "R3";
        compared++;
        if ({hs_req, ls_req, shutdown} !== {m_hs, m_ls, m_sd}) begin
            mismatched++;
            $display("FAIL %s [%s] t=%0t hs/ls/sd actual=%b%b%b expected=%b%b%b",
                     tag, phase, $time, hs_req, ls_req, shutdown, m_hs, m_ls, m_sd);
        end
        compared++;
        if ((hs_req && ls_req) || (shutdown && (hs_req || ls_req))) begin
            mismatched++;
            $display("FAIL R9 t=%0t actual=%b%b%b expected=at most one set",
                     $time, hs_req, ls_req, shutdown);
        end
    endtask

    task automatic drive(input logic [1:0] code, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_now();
            {above, below} = code;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        phase = "R1";
        repeat (3) @(negedge clk);
        check_now();
        @(negedge clk); check_now();
        rst = 1'b0;

        phase = "R2";  drive(2'b10, 6);
        phase = "R3";  drive(2'b01, 6);
        phase = "R5";  drive(2'b00, HOLD);      // exactly HOLD: no shutdown
        drive(2'b01, 4);
        phase = "R4";  drive(2'b00, HOLD + 1);  // HOLD+1: shutdown
        drive(2'b00, 4);
        phase = "R6";  drive(2'b10, 5);
        phase = "R7";  drive(2'b11, HOLD + 4);
        phase = "R6";  drive(2'b01, 5);
        phase = "R7";  drive(2'b11, 10); drive(2'b00, HOLD); // mixed codes accumulate
        drive(2'b10, 4);
        phase = "R8";
        for (int k = 0; k < 4; k++) begin
            drive(2'b00, HOLD - 2);
            drive(2'b01, 1);
        end
        drive(2'b01, 4);

        phase = "rand";
        for (int k = 0; k < 600; k++) begin
            int sel = $urandom_range(0, 9);
            int len;
            logic [1:0] code;
            case (sel)
                0, 1, 2: code = 2'b10;
                3, 4, 5: code = 2'b01;
                6, 7, 8: code = 2'b00;
                default: code = 2'b11;
            endcase
            if (is_mid(code) && $urandom_range(0, 1) == 1)
                len = HOLD + $urandom_range(0, 2) - 1;
            else
                len = $urandom_range(1, 2 * HOLD);
            drive(code, len);
        end
        drive(2'b10, 5);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule